// File: doc/BRIEF.md
# I2C Slave Receiver with 10-bit Addressing

This block is an I2C bus slave that accepts write transfers from a bus master that uses 10-bit addressing. The raw SCL and SDA pin levels are brought through a synchronizer. The block watches for START and STOP conditions and shifts in bits on rising SCL. It answers a byte by pulling SDA low through `sda_oe`, and it changes SDA only while SCL is low.

A transfer opens with two address bytes. The first byte holds a fixed prefix, the top two address bits and the direction bit. The second byte holds the low eight address bits. When general call is enabled, the address byte 0x00 is also accepted. Every data byte that follows is placed in a holding register and raises a full flag. The host answers the next byte with ACK or NAK through `nak_next`. If a byte completes while the holding register is still full, the block holds SCL low until the host reads the register. A STOP or a repeated START that ends an addressed transfer sets a stop flag.

Top module: `i2c_slave10_rx`

## Requirements
- R1: After reset, `rx_full`, `stop_flag`, `irq_rx`, `irq_stop`, `sda_oe` and `scl_oe` are all 0.
- R2: The first byte after a START is acknowledged only when it equals {5'b11110, own_addr[9:8], 1'b0}. Bits 7:3 are 11110, bits 2:1 are the top address bits and bit 0 is the write bit (0). Any other value, including a set bit 0, gets NAK, and the slave ignores the bus until the next START.
- R3: The second address byte is acknowledged only when it equals own_addr[7:0]. On a mismatch the slave gives NAK, acknowledges and stores no later byte, and waits for the next START.
- R4: Each completed data byte is presented on `rx_data` and sets `rx_full`; `irq_rx` follows `rx_full`. A one-cycle `rd_data` pulse clears `rx_full`.
- R5: A data byte is acknowledged (SDA held low during the ninth clock) when `nak_next` is 0 at the byte's eighth rising SCL. When `nak_next` is 1 the byte gets NAK (SDA left high), and it is still stored.
- R6: A STOP, or a repeated START, that arrives after the slave has been addressed sets `stop_flag`; `irq_stop` follows `stop_flag`. A `rd_status` pulse clears it. A STOP seen while the slave is not addressed leaves `stop_flag` at 0.
- R7: When `gc_en` is 1, a first address byte of 0x00 is acknowledged and the data bytes that follow are received. When `gc_en` is 0, 0x00 gets NAK.
- R8: If a data byte completes while `rx_full` is still 1, the slave holds SCL low (`scl_oe`=1) from the next SCL fall until `rd_data` arrives. It then presents the new byte, sets `rx_full`, drives the acknowledge and releases SCL. No byte is lost.
- R9: While `en` is 0 the slave drives neither line, acknowledges nothing and sets no flag.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| gc_en | input | 1 | Accept the general-call address 0x00 |
| nak_next | input | 1 | Answer the next data byte with NAK |
| own_addr | input | 10 | Programmed 10-bit slave address |
| rd_data | input | 1 | Host read strobe for the data register; clears `rx_full` |
| rd_status | input | 1 | Host read strobe for status; clears `stop_flag` |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | Data register holds an unread byte |
| stop_flag | output | 1 | Addressed transfer ended by STOP or repeated START |
| irq_rx | output | 1 | Receive interrupt |
| irq_stop | output | 1 | Stop interrupt |

## Verification
The hardest case to reach is the clock hold. It needs a second byte to complete while the first is still unread, and the host read has to come only after SCL has already been pulled low. The bench holds back its read and lets a second byte run. A forked process waits several hundred cycles, confirms that SCL is held and that the old byte is intact, and only then issues the read. Meanwhile the bus master task stays blocked on the held clock. The repeated-START path is reached by sending a new START straight after a data acknowledge, with no STOP in between.

// File: rtl/i2c_slave10_rx.sv
module i2c_slave10_rx #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       gc_en,
  input  logic       nak_next,
  input  logic [9:0] own_addr,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       stop_flag,
  output logic       irq_rx,
  output logic       irq_stop
);
  typedef enum logic [1:0] {IDLE = 2'd0, ADR_HI = 2'd1, ADR_LO = 2'd2, DATA = 2'd3} st_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  st_t  st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] byte_in;
  logic ack_pend, ack_val, stall, hold;

  assign scl_s    = scl_sh[SYNC-1];
  assign sda_s    = sda_sh[SYNC-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign byte_in  = {shreg[6:0], sda_s};
  assign scl_oe   = hold;
  assign irq_rx   = rx_full;
  assign irq_stop = stop_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rx_data   <= '0;
      rx_full   <= 1'b0;
      stop_flag <= 1'b0;
      sda_oe    <= 1'b0;
      ack_pend  <= 1'b0;
      ack_val   <= 1'b0;
      stall     <= 1'b0;
      hold      <= 1'b0;
    end else begin
      if (rd_data)   rx_full   <= 1'b0;
      if (rd_status) stop_flag <= 1'b0;
      if (!en) begin
        st       <= IDLE;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
        stall    <= 1'b0;
        hold     <= 1'b0;
      end else if (start_ev || stop_ev) begin
        if (st == DATA) stop_flag <= 1'b1;
        st       <= start_ev ? ADR_HI : IDLE;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
        stall    <= 1'b0;
        hold     <= 1'b0;
      end else if (st != IDLE) begin
        if (stall) begin
          if (scl_fall) hold <= 1'b1;
          if (!rx_full) begin
            rx_data <= shreg;
            rx_full <= 1'b1;
            stall   <= 1'b0;
            hold    <= 1'b0;
            if (hold) sda_oe <= ~nak_next;
            else begin
              ack_pend <= 1'b1;
              ack_val  <= ~nak_next;
            end
          end
        end else if (scl_rise) begin
          if (cnt < 4'd8) begin
            shreg <= byte_in;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              unique case (st)
                ADR_HI: begin
                  if (byte_in == {5'b11110, own_addr[9:8], 1'b0}) begin
                    st <= ADR_LO; ack_pend <= 1'b1; ack_val <= 1'b1;
                  end else if (gc_en && byte_in == 8'h00) begin
                    st <= DATA; ack_pend <= 1'b1; ack_val <= 1'b1;
                  end else st <= IDLE;
                end
                ADR_LO: begin
                  if (byte_in == own_addr[7:0]) begin
                    st <= DATA; ack_pend <= 1'b1; ack_val <= 1'b1;
                  end else st <= IDLE;
                end
                DATA: begin
                  if (rx_full && !rd_data) stall <= 1'b1;
                  else begin
                    rx_data  <= byte_in;
                    rx_full  <= 1'b1;
                    ack_pend <= 1'b1;
                    ack_val  <= ~nak_next;
                  end
                end
                default: st <= IDLE;
              endcase
            end
          end else if (cnt == 4'd8) cnt <= 4'd9;
        end else if (scl_fall) begin
          if (ack_pend) begin
            sda_oe   <= ack_val;
            ack_pend <= 1'b0;
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave10_rx_chk.sv
module i2c_slave10_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rd_data,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       rx_full,
  input logic       stop_flag,
  input logic       irq_rx,
  input logic       irq_stop,
  input logic [1:0] st
);
  // R10
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_oe)) |-> !$past(scl_s));
  // R4
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rd_data) |=> !rx_full);
  // R8
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (rx_full || $past(rx_full)));
  // R4
  rx_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ($past(st) == 2'd3));
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !scl_oe));
  // R6
  irq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stop == stop_flag);
  // R4
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == rx_full);
endmodule

bind i2c_slave10_rx i2c_slave10_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd_data(rd_data), .scl_s(scl_s),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .rx_full(rx_full), .stop_flag(stop_flag),
  .irq_rx(irq_rx), .irq_stop(irq_stop), .st(st)
);

// File: tb/sim_i2c_slave10_rx.sv
`timescale 1ns/1ps
module sim_i2c_slave10_rx;
  localparam int Q = 8;
  logic clk = 0, rst_n = 0, en = 0, gc_en = 0, nak_next = 0;
  logic [9:0] own_addr = 10'h2A5;
  logic rd_data = 0, rd_status = 0;
  logic m_scl_lo = 0, m_sda_lo = 0;
  logic scl_oe, sda_oe, rx_full, stop_flag, irq_rx, irq_stop;
  logic [7:0] rx_data;
  wire scl_bus = !(m_scl_lo || scl_oe);
  wire sda_bus = !(m_sda_lo || sda_oe);
  int n_chk = 0, n_fail = 0, viol = 0;
  logic exp_full = 0, exp_stop = 0;
  logic [7:0] exp_data = 0;
  logic p_scl = 1, p_oe = 0;
  logic ackb;

  always #2.5 clk = ~clk;

  i2c_slave10_rx u0 (.clk(clk), .rst_n(rst_n), .en(en), .gc_en(gc_en), .nak_next(nak_next),
    .own_addr(own_addr), .rd_data(rd_data), .rd_status(rd_status), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_full(rx_full), .stop_flag(stop_flag),
    .irq_rx(irq_rx), .irq_stop(irq_stop));

  always @(negedge clk) begin
    if (rst_n && p_scl && scl_bus && (sda_oe != p_oe)) viol++;
    p_scl <= scl_bus;
    p_oe  <= sda_oe;
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic scl_up(); m_scl_lo = 0; while (!scl_bus) @(negedge clk); endtask

  task automatic start_c();
    m_sda_lo = 0; m_scl_lo = 0; wq(); m_sda_lo = 1; wq(); m_scl_lo = 1; wq();
  endtask
  task automatic restart_c();
    m_sda_lo = 0; wq(); scl_up(); wq(); m_sda_lo = 1; wq(); m_scl_lo = 1; wq();
  endtask
  task automatic stop_c();
    m_sda_lo = 1; wq(); scl_up(); wq(); m_sda_lo = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_lo = !b[i]; wq(); scl_up(); wq(); wq(); m_scl_lo = 1; wq();
    end
    m_sda_lo = 0; wq(); scl_up(); wq(); ack = !sda_bus; wq(); m_scl_lo = 1; wq();
  endtask
  task automatic host_read();
    rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk); exp_full = 0;
  endtask
  task automatic host_status();
    rd_status = 1; @(negedge clk); rd_status = 0; @(negedge clk); exp_stop = 0;
  endtask
  task automatic cmp_model(input string r);
    chk({r, " full"}, rx_full, exp_full);
    chk({r, " irq_rx"}, irq_rx, exp_full);
    chk({r, " stop"}, stop_flag, exp_stop);
    chk({r, " irq_stop"}, irq_stop, exp_stop);
    if (exp_full) chk({r, " data"}, rx_data, exp_data);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_full", rx_full, 0); chk("R1 stop", stop_flag, 0);
    chk("R1 sda_oe", sda_oe, 0);   chk("R1 scl_oe", scl_oe, 0);
    chk("R1 irq", {irq_rx, irq_stop}, 0);
    en = 1; wq();

    // R2 R3 R4 R5 R6 normal write, STOP
    start_c();
    send_byte(8'hF4, ackb); chk("R2 first byte ack", ackb, 1);
    send_byte(8'hA5, ackb); chk("R3 second byte ack", ackb, 1);
    send_byte(8'h3C, ackb); chk("R5 data ack", ackb, 1);
    exp_full = 1; exp_data = 8'h3C; cmp_model("R4 byte stored");
    host_read(); cmp_model("R4 after read");
    nak_next = 1;
    send_byte(8'hC3, ackb); chk("R5 data nak", ackb, 0);
    exp_full = 1; exp_data = 8'hC3; cmp_model("R5 nak byte stored");
    host_read(); nak_next = 0;
    stop_c(); exp_stop = 1; cmp_model("R6 stop sets flag");
    host_status(); cmp_model("R6 status read clears");

    // R2 wrong high address bits, then R/W=1
    start_c();
    send_byte(8'hF6, ackb); chk("R2 wrong hi bits nak", ackb, 0);
    send_byte(8'hA5, ackb); chk("R2 ignored after mismatch", ackb, 0);
    send_byte(8'h55, ackb); chk("R2 no data ack", ackb, 0);
    stop_c(); cmp_model("R6 unaddressed stop no flag");
    start_c();
    send_byte(8'hF5, ackb); chk("R2 read bit nak", ackb, 0);
    stop_c();

    // R3 wrong low byte
    start_c();
    send_byte(8'hF4, ackb); chk("R3 first ok", ackb, 1);
    send_byte(8'hA4, ackb); chk("R3 low mismatch nak", ackb, 0);
    send_byte(8'h77, ackb); chk("R3 later byte ignored", ackb, 0);
    stop_c(); cmp_model("R3 nothing stored");

    // R7 general call
    start_c();
    send_byte(8'h00, ackb); chk("R7 gc disabled nak", ackb, 0);
    stop_c();
    gc_en = 1;
    start_c();
    send_byte(8'h00, ackb); chk("R7 gc ack", ackb, 1);
    send_byte(8'h9A, ackb); chk("R7 gc data ack", ackb, 1);
    exp_full = 1; exp_data = 8'h9A; cmp_model("R7 gc data stored");
    host_read();
    // R6 repeated start
    restart_c(); exp_stop = 1; cmp_model("R6 restart sets flag");
    host_status();
    gc_en = 0;
    send_byte(8'hF4, ackb); chk("R6 after restart addr", ackb, 1);
    send_byte(8'hA5, ackb);

    // R8 clock hold
    send_byte(8'h11, ackb); exp_full = 1; exp_data = 8'h11;
    fork
      begin
        repeat (300) @(negedge clk);
        chk("R8 scl held", scl_oe, 1);
        chk("R8 old byte kept", rx_data, 8'h11);
        host_read();
      end
    join_none
    send_byte(8'h22, ackb); chk("R8 ack after release", ackb, 1);
    chk("R8 scl released", scl_oe, 0);
    exp_full = 1; exp_data = 8'h22; cmp_model("R8 new byte");
    host_read();
    stop_c(); exp_stop = 1; cmp_model("R8 stop"); host_status();

    // R9 disabled
    en = 0; wq();
    start_c();
    send_byte(8'hF4, ackb); chk("R9 no ack", ackb, 0);
    send_byte(8'hA5, ackb); chk("R9 no ack 2", ackb, 0);
    stop_c(); cmp_model("R9 no flags");
    chk("R9 lines free", {scl_oe, sda_oe}, 0);

    // R10
    chk("R10 sda changes with scl high", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule